// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home-node directory for a small set of memory blocks shared by a fixed number of caches. For every block it records a coherence state (uncached, shared or exclusive), a bit-vector of the caches holding a copy, and the owning cache while the block is exclusive. Caches send it read misses, write misses and write-backs. It answers with data replies, write grants (data plus write permission), invalidations to sharers and fetch requests to an owner. It also drives a memory write port whenever owner data or write-back data has to be stored.

Only one transaction is in flight at a time. A request that needs other caches to act first (invalidation acknowledgements or owner data) keeps the controller busy until those answers arrive. The request port stays stalled during that time, so the directory alone decides the order in which conflicting requests are served. Memory is read through a same-cycle read port. The interconnect and the caches sit outside the block.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every block is uncached with an empty sharer set, `req_ready` is high and no message is being sent.
- R2: A read miss (`req_type`=0) to an uncached block accepted at edge k sends, after edge k, one message of kind DATA (`msg_kind`=0) to the requester carrying the memory word. The block becomes shared with the requester as its only sharer.
- R3: A write miss (`req_type`=1) to an uncached block sends a GRANT (`msg_kind`=3) with the memory word to the requester. The block becomes exclusive, owned by the requester.
- R4: A read miss to a shared block sends DATA with the memory word and adds the requester to the sharer set.
- R5: A write miss to a shared block sends one INV (`msg_kind`=1) per cycle to every other sharer, lowest cache index first. It sends the GRANT only in the cycle after the last acknowledgement arrives. The requester then becomes the exclusive owner. If the requester is the only sharer, the GRANT follows at once.
- R6: A read miss to an exclusive block sends FETCH (`msg_kind`=2) to the owner. When the owner data arrives, it is written to memory and sent as DATA to the requester. The block becomes shared by the old owner and the requester.
- R7: A write miss to an exclusive block sends FETCH to the owner. When the owner data arrives, it is written to memory and sent as GRANT to the requester. The block stays exclusive, now owned by the requester.
- R8: A write-back (`req_type`=2) from the owner of an exclusive block writes its data to memory and makes the block uncached, with no message sent.
- R9: A write-back from a cache that is not the owner, or to a block that is not exclusive, has no effect: memory, the block's state and its sharers are unchanged.
- R10: `req_ready` is low from the edge that accepts a request needing invalidations or a fetch until the edge that completes it. Requests presented meanwhile are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | CW | Requesting cache index |
| req_blk | input | BW | Block index |
| req_data | input | DW | Write-back data |
| ack_valid | input | 1 | Invalidation acknowledgement present |
| ack_src | input | CW | Acknowledging cache index |
| fetch_valid | input | 1 | Owner data returned |
| fetch_data | input | DW | Owner data |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 0 DATA, 1 INV, 2 FETCH, 3 GRANT |
| msg_dst | output | CW | Destination cache index |
| msg_data | output | DW | Payload (zero for INV and FETCH) |
| mem_rd_addr | output | BW | Memory read address |
| mem_rd_data | input | DW | Memory read data, same cycle |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | BW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
The assertions take for granted that caches behave: an acknowledgement comes only from a cache that was sent an invalidation and has not yet answered. Owner data comes only while a fetch is outstanding. A miss to an exclusive block never comes from the owner itself. The stimulus respects these rules because the bench's cache responders answer only messages they actually receive, one acknowledgement per cycle, and its request sequence never sends a miss from a block's current owner. Write-backs from wrong caches are sent on purpose, since the block must ignore them.

// File: rtl/dir_coh_pkg.sv
// Shared encodings for the directory coherence controller.
// Assumes request, message and state codes are fixed two-bit values.
package dir_coh_pkg;
    typedef enum logic [1:0] {ST_UNC = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2} dstate_e;
    typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_WBACK = 2'd2} rq_kind_e;
    typedef enum logic [1:0] {MK_DATA = 2'd0, MK_INV = 2'd1, MK_FETCH = 2'd2, MK_GRANT = 2'd3} msg_kind_e;
    typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_INVAL = 2'd1, FS_FETCH = 2'd2} fsm_e;
endpackage

// File: rtl/dir_lowbit.sv
// Lowest-set-bit encoder: returns the index of the least significant set bit.
// Assumes the caller ignores idx when any is low.
module dir_lowbit #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/dir_table.sv
// Directory entry storage: state, sharer vector and owner per block.
// Assumes one combinational read port and one write port, both on the same block.
module dir_table
    import dir_coh_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int NENT   = 4,
    localparam int CW    = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int BW    = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BW-1:0]     blk,
    output dstate_e           rd_state,
    output logic [NCACHE-1:0] rd_shr,
    output logic [CW-1:0]     rd_own,
    input  logic              we,
    input  dstate_e           wr_state,
    input  logic [NCACHE-1:0] wr_shr,
    input  logic [CW-1:0]     wr_own
);
    dstate_e           st_q  [NENT];
    logic [NCACHE-1:0] shr_q [NENT];
    logic [CW-1:0]     own_q [NENT];

    // read the addressed entry
    always_comb begin
        rd_state = st_q[blk];
        rd_shr   = shr_q[blk];
        rd_own   = own_q[blk];
    end

    // clear all entries on reset, else update the addressed one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                st_q[i]  <= ST_UNC;
                shr_q[i] <= '0;
                own_q[i] <= '0;
            end
        end else if (we) begin
            st_q[blk]  <= wr_state;
            shr_q[blk] <= wr_shr;
            own_q[blk] <= wr_own;
        end
    end

    // per-entry consistency between state and sharer vector
    for (genvar g = 0; g < NENT; g++) begin : g_chk
        a_r1_unc_empty: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == ST_UNC) |-> (shr_q[g] == '0));
        a_r4_shr_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == ST_SHR) |-> (shr_q[g] != '0));
        a_r7_exc_sole_owner: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == ST_EXC) |-> ($onehot(shr_q[g]) && shr_q[g][own_q[g]]));
    end
endmodule

// File: rtl/dir_coherence_ctrl.sv
// Home-node directory controller: serves read/write misses and write-backs,
// collects invalidation acknowledgements and recalls owner data.
// Assumes acks only from invalidated caches, owner data only while a fetch
// is outstanding, and no miss from a block's own owner.
module dir_coherence_ctrl
    import dir_coh_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int NENT   = 4,
    parameter int DW     = 16,
    localparam int CW    = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int BW    = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_type,
    input  logic [CW-1:0] req_src,
    input  logic [BW-1:0] req_blk,
    input  logic [DW-1:0] req_data,
    input  logic          ack_valid,
    input  logic [CW-1:0] ack_src,
    input  logic          fetch_valid,
    input  logic [DW-1:0] fetch_data,
    output logic          msg_valid,
    output logic [1:0]    msg_kind,
    output logic [CW-1:0] msg_dst,
    output logic [DW-1:0] msg_data,
    output logic [BW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_we,
    output logic [BW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);
    fsm_e              fsm, n_fsm;
    logic [NCACHE-1:0] todo, n_todo, pend, n_pend;
    logic [CW-1:0]     cur_src;
    logic [BW-1:0]     cur_blk, blk;
    logic              cur_wr, latch;
    logic              n_mv;
    msg_kind_e         n_kind;
    logic [CW-1:0]     n_dst;
    logic [DW-1:0]     n_data;
    dstate_e           rd_state, wr_state;
    logic [NCACHE-1:0] rd_shr, wr_shr, src_bit, cur_bit, ack_bit, others, pend_nx;
    logic [CW-1:0]     rd_own, wr_own, low_idx;
    logic              tbl_we, low_any;

    assign req_ready   = (fsm == FS_IDLE);
    assign blk         = (fsm == FS_IDLE) ? req_blk : cur_blk;
    assign mem_rd_addr = blk;
    assign mem_waddr   = blk;

    dir_table #(.NCACHE(NCACHE), .NENT(NENT)) u_table (
        .clk(clk), .rst_n(rst_n), .blk(blk),
        .rd_state(rd_state), .rd_shr(rd_shr), .rd_own(rd_own),
        .we(tbl_we), .wr_state(wr_state), .wr_shr(wr_shr), .wr_own(wr_own)
    );

    dir_lowbit #(.N(NCACHE)) u_low (.vec(todo), .idx(low_idx), .any(low_any));

    // one-hot decodes of requester, current transaction and acknowledger
    always_comb begin
        src_bit = '0; src_bit[req_src] = 1'b1;
        cur_bit = '0; cur_bit[cur_src] = 1'b1;
        ack_bit = '0;
        if (ack_valid) ack_bit[ack_src] = 1'b1;
        others  = rd_shr & ~src_bit;
        pend_nx = pend & ~ack_bit;
    end

    // directory decision: next state, table update, memory write, message
    always_comb begin
        n_fsm = fsm; n_todo = todo; n_pend = pend; latch = 1'b0;
        tbl_we = 1'b0; wr_state = rd_state; wr_shr = rd_shr; wr_own = rd_own;
        mem_we = 1'b0; mem_wdata = '0;
        n_mv = 1'b0; n_kind = MK_DATA; n_dst = cur_src; n_data = '0;
        unique case (fsm)
            FS_IDLE: if (req_valid) begin
                latch = 1'b1;
                n_dst = req_src;
                case (rq_kind_e'(req_type))
                    RQ_READ: if (rd_state == ST_EXC) begin
                        n_mv = 1'b1; n_kind = MK_FETCH; n_dst = rd_own; n_fsm = FS_FETCH;
                    end else begin
                        n_mv = 1'b1; n_kind = MK_DATA; n_data = mem_rd_data;
                        tbl_we = 1'b1; wr_state = ST_SHR; wr_shr = rd_shr | src_bit;
                    end
                    RQ_WRITE: if (rd_state == ST_EXC) begin
                        n_mv = 1'b1; n_kind = MK_FETCH; n_dst = rd_own; n_fsm = FS_FETCH;
                    end else if (rd_state == ST_SHR && others != '0) begin
                        n_todo = others; n_pend = others; n_fsm = FS_INVAL;
                    end else begin
                        n_mv = 1'b1; n_kind = MK_GRANT; n_data = mem_rd_data;
                        tbl_we = 1'b1; wr_state = ST_EXC; wr_shr = src_bit; wr_own = req_src;
                    end
                    RQ_WBACK: if (rd_state == ST_EXC && rd_own == req_src) begin
                        mem_we = 1'b1; mem_wdata = req_data;
                        tbl_we = 1'b1; wr_state = ST_UNC; wr_shr = '0;
                    end
                    default: ;
                endcase
            end
            FS_INVAL: begin
                n_pend = pend_nx;
                if (low_any) begin
                    n_mv = 1'b1; n_kind = MK_INV; n_dst = low_idx;
                    n_todo = todo; n_todo[low_idx] = 1'b0;
                end else if (pend_nx == '0) begin
                    n_mv = 1'b1; n_kind = MK_GRANT; n_data = mem_rd_data;
                    tbl_we = 1'b1; wr_state = ST_EXC; wr_shr = cur_bit; wr_own = cur_src;
                    n_fsm = FS_IDLE;
                end
            end
            FS_FETCH: if (fetch_valid) begin
                mem_we = 1'b1; mem_wdata = fetch_data;
                n_mv = 1'b1; n_data = fetch_data; tbl_we = 1'b1; n_fsm = FS_IDLE;
                if (cur_wr) begin
                    n_kind = MK_GRANT; wr_state = ST_EXC; wr_shr = cur_bit; wr_own = cur_src;
                end else begin
                    n_kind = MK_DATA; wr_state = ST_SHR; wr_shr = rd_shr | cur_bit;
                end
            end
            default: n_fsm = FS_IDLE;
        endcase
    end

    // register control state, latched request and outgoing message
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm <= FS_IDLE; todo <= '0; pend <= '0;
            cur_src <= '0; cur_blk <= '0; cur_wr <= 1'b0;
            msg_valid <= 1'b0; msg_kind <= MK_DATA; msg_dst <= '0; msg_data <= '0;
        end else begin
            fsm <= n_fsm; todo <= n_todo; pend <= n_pend;
            if (latch) begin
                cur_src <= req_src; cur_blk <= req_blk;
                cur_wr  <= (rq_kind_e'(req_type) == RQ_WRITE);
            end
            msg_valid <= n_mv; msg_kind <= n_kind; msg_dst <= n_dst; msg_data <= n_data;
        end
    end

    a_r5_grant_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_GRANT) |-> (pend == '0));
    a_r5_inv_awaits_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_INV) |-> pend[msg_dst]);
    a_r10_ready_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> req_ready);
endmodule

// File: tb/dir_coherence_ctrl_bench.sv
module dir_coherence_ctrl_bench;
    localparam int NC = 4;
    localparam int NE = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_type = '0;
    logic [1:0] req_src = '0, req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic ack_valid = 1'b0;
    logic [1:0] ack_src = '0;
    logic fetch_valid = 1'b0;
    logic [DW-1:0] fetch_data = '0;
    logic msg_valid;
    logic [1:0] msg_kind, msg_dst;
    logic [DW-1:0] msg_data;
    logic [1:0] mem_rd_addr, mem_waddr;
    logic [DW-1:0] mem_rd_data, mem_wdata;
    logic mem_we;
    logic [DW-1:0] bmem [NE];

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    dir_coherence_ctrl #(.NCACHE(NC), .NENT(NE), .DW(DW)) u_dir_coherence_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .ack_valid(ack_valid), .ack_src(ack_src), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_dst(msg_dst), .msg_data(msg_data), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    // bench memory behind the block's ports
    assign mem_rd_data = bmem[mem_rd_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) bmem[i] <= 16'h1000 + 16'(i) * 16'h0111;
        end else if (mem_we) bmem[mem_waddr] <= mem_wdata;
    end

    // reference model: 0 uncached, 1 shared, 2 exclusive
    int ms [NE];
    bit [NC-1:0] mshr [NE];
    int mown [NE];
    logic [DW-1:0] mmem [NE];
    int ph, cs, cb;
    bit cw;
    int q_todo [$];
    bit [NC-1:0] mpend, oth;
    bit e_mv, e_ready;
    int e_kind, e_dst;
    logic [DW-1:0] e_data;
    string etag = "R1", mtag = "R8";

    task automatic emit(input int k, input int d, input logic [DW-1:0] v, input string t);
        e_mv = 1'b1; e_kind = k; e_dst = d; e_data = v; etag = t;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin
                ms[i] = 0; mshr[i] = '0; mown[i] = 0; mmem[i] = 16'h1000 + 16'(i) * 16'h0111;
            end
            ph = 0; q_todo.delete(); mpend = '0; e_mv = 1'b0; e_ready = 1'b1;
        end else begin
            e_mv = 1'b0;
            if (ph == 0 && req_valid) begin
                int s, b;
                s = int'(req_src); b = int'(req_blk); cs = s; cb = b;
                if (req_type == 2'd0) begin
                    cw = 1'b0;
                    if (ms[b] == 2) begin emit(2, mown[b], '0, "R6"); ph = 2; end
                    else begin
                        emit(0, s, mmem[b], (ms[b] == 0) ? "R2" : "R4");
                        ms[b] = 1; mshr[b][s] = 1'b1;
                    end
                end else if (req_type == 2'd1) begin
                    cw = 1'b1;
                    oth = (ms[b] == 1) ? (mshr[b] & ~(NC'(1) << s)) : '0;
                    if (ms[b] == 2) begin emit(2, mown[b], '0, "R7"); ph = 2; end
                    else if (oth != '0) begin
                        for (int i = 0; i < NC; i++) if (oth[i]) q_todo.push_back(i);
                        mpend = oth; ph = 1;
                    end else begin
                        emit(3, s, mmem[b], (ms[b] == 0) ? "R3" : "R5");
                        ms[b] = 2; mshr[b] = NC'(1) << s; mown[b] = s;
                    end
                end else if (req_type == 2'd2) begin
                    if (ms[b] == 2 && mown[b] == s) begin
                        mmem[b] = req_data; ms[b] = 0; mshr[b] = '0; mtag = "R8";
                    end else mtag = "R9";
                end
            end else if (ph == 1) begin
                if (ack_valid) mpend[ack_src] = 1'b0;
                if (q_todo.size() > 0) emit(1, q_todo.pop_front(), '0, "R5");
                else if (mpend == '0) begin
                    emit(3, cs, mmem[cb], "R5");
                    ms[cb] = 2; mshr[cb] = NC'(1) << cs; mown[cb] = cs; ph = 0;
                end
            end else if (ph == 2 && fetch_valid) begin
                mmem[cb] = fetch_data; mtag = cw ? "R7" : "R6";
                if (cw) begin
                    emit(3, cs, fetch_data, "R7");
                    ms[cb] = 2; mshr[cb] = NC'(1) << cs; mown[cb] = cs;
                end else begin
                    emit(0, cs, fetch_data, "R6");
                    ms[cb] = 1; mshr[cb] = (NC'(1) << mown[cb]) | (NC'(1) << cs);
                end
                ph = 0;
            end
            e_ready = (ph == 0);
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    // compare against the model each cycle, then play the caches
    int ackq [$];
    int fcnt = 0, fown = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 ready", 32'(req_ready), 32'(e_ready));
            chk({etag, " msg_valid"}, 32'(msg_valid), 32'(e_mv));
            if (e_mv && msg_valid) begin
                chk({etag, " kind"}, 32'(msg_kind), 32'(e_kind));
                chk({etag, " dst"}, 32'(msg_dst), 32'(e_dst));
                chk({etag, " data"}, 32'(msg_data), 32'(e_data));
            end
            for (int i = 0; i < NE; i++) chk({mtag, " memory"}, 32'(bmem[i]), 32'(mmem[i]));
            if (msg_valid && msg_kind == 2'd1) ackq.push_back(int'(msg_dst));
            if (ackq.size() > 0) begin ack_valid <= 1'b1; ack_src <= 2'(ackq.pop_front()); end
            else ack_valid <= 1'b0;
            if (fcnt == 1) begin
                fetch_valid <= 1'b1; fetch_data <= 16'hF000 | 16'(fown << 4) | 16'(cb);
            end else fetch_valid <= 1'b0;
            if (fcnt > 0) fcnt--;
            if (msg_valid && msg_kind == 2'd2) begin fcnt = 2; fown = int'(msg_dst); end
        end
    end

    // hold a request until the block accepts it
    task automatic do_req(input int t, input int s, input int b, input logic [DW-1:0] d);
        bit acc;
        req_valid = 1'b1; req_type = 2'(t); req_src = 2'(s); req_blk = 2'(b); req_data = d;
        do begin acc = req_ready; @(negedge clk); end while (!acc);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 idle", 32'(msg_valid), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        do_req(0, 0, 0, '0);          // R2
        do_req(0, 1, 0, '0);          // R4
        do_req(0, 2, 0, '0);          // R4
        do_req(1, 0, 0, '0);          // R5 two invalidations
        do_req(1, 2, 0, '0);          // R7 owner recall
        do_req(0, 1, 0, '0);          // R6
        do_req(2, 3, 0, 16'hDEAD);    // R9 non-owner on shared
        do_req(1, 3, 1, '0);          // R3
        do_req(2, 0, 1, 16'hBEEF);    // R9 non-owner on exclusive
        do_req(2, 3, 1, 16'h5A5A);    // R8
        do_req(0, 0, 1, '0);          // R2 after write-back
        do_req(1, 0, 1, '0);          // R5 sole sharer upgrade
        for (int c = 0; c < NC; c++) do_req(0, c, 3, '0);
        do_req(1, 1, 3, '0);          // R5 three invalidations
        do_req(0, 2, 3, '0);          // R6
        do_req(1, 0, 2, '0);          // R3
        do_req(2, 0, 2, 16'h7777);    // R8
        repeat (6) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule